// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns an asynchronous, idle-high serial line into parallel words. It runs on a clock much faster than the bit rate. The bit period is a runtime input given as a count of clock cycles. The line first passes through a synchronizer. A high-to-low transition then marks the origin of a frame. Each bit of the frame is sampled near its centre by counting cycles from that origin.

The receiver picks up three settings at the start of each frame: the word length (5 to 9 bits), the bit order, and the parity mode. The parity mode can be none, odd, even, forced zero or forced one. When the stop bit has been sampled, the receiver gives a one-cycle valid pulse. The assembled word is presented at the same time, with three flags: a start bit that read high, a parity mismatch, and a stop bit that read low. A start bit that reads high does not end the frame. The rest of the frame is still decoded and delivered.

Top module: `uart_frame_rx`

## Requirements
- R1: With the line held high, no valid pulse is produced. A frame is opened only by a high-to-low transition of the synchronized line.
- R2: Frame bit n is sampled half a period plus n periods after the origin, where half is `cfg_period_i >> 1`. Index 0 is the start bit, indexes 1..N are data, then comes parity (if enabled) and then the stop bit at index S. `valid_o` is high after rising edge number 3 + half + S*period, counted from the first rising edge at which `rxd_i` is low.
- R3: `cfg_nbits_i` gives the word length N in binary, from 5 to 9. Bits of `data_o` at position N and above read 0.
- R4: With `cfg_msb_first_i`=0, the first data bit received lands in `data_o[0]`. With `cfg_msb_first_i`=1, it lands in `data_o[N-1]`.
- R5: Parity code 1 (odd) requires the total number of ones in the data and the parity bit to be odd. Code 2 (even) requires that total to be even. A mismatch raises `parity_err_o`.
- R6: Parity code 3 requires a parity bit of 0, and code 4 requires a parity bit of 1. Any other value raises `parity_err_o`.
- R7: Parity code 0 has no parity slot. The stop bit is at index N+1, and `parity_err_o` stays 0.
- R8: A start bit that samples 1 raises `start_err_o`. The data bits are still assembled and delivered with that frame.
- R9: A stop bit that samples 0 raises `stop_err_o`. The receiver then waits for a new falling edge and accepts the next frame normally.
- R10: Word length, bit order and parity mode are captured when the frame opens. Changes to them during a frame do not affect that frame.
- R11: A synchronous active-high `rst` clears `data_o`, `valid_o` and all flags, and abandons any frame in progress.
- R12: `valid_o` lasts exactly one cycle. The error flags are high only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| cfg_period_i | input | PER_W | Clock cycles per bit, at least 4 |
| cfg_nbits_i | input | 4 | Data bits per word, 5..9 |
| cfg_msb_first_i | input | 1 | 1: MSB first, 0: LSB first |
| cfg_parity_i | input | 3 | 0 none, 1 odd, 2 even, 3 zero, 4 one |
| data_o | output | 9 | Last received word, upper bits zero |
| valid_o | output | 1 | One-cycle pulse when a frame completes |
| start_err_o | output | 1 | Start bit sampled high (with valid) |
| parity_err_o | output | 1 | Parity check failed (with valid) |
| stop_err_o | output | 1 | Stop bit sampled low (with valid) |

## Verification
A wrong bit index or timer count shows up at the ports within one frame. It appears as a valid pulse on the wrong cycle, a word with bits shifted or dropped, or a stop flag on a good frame. The exact valid cycle is therefore checked against the formula in R2. Broken configuration capture only shows up when settings change mid-frame, so one frame does exactly that. A stuck frame state shows up as a missing pulse, which the bench detects as an undrained expectation queue at the end of the run.

// File: rtl/urx_pkg.sv
package urx_pkg;

  localparam int unsigned WORD_MAX = 9;
  localparam int unsigned WORD_MIN = 5;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } par_mode_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  // True when the sampled parity bit agrees with the selected mode.
  function automatic logic parity_good(par_mode_e mode, logic pbit,
                                       logic [WORD_MAX-1:0] word);
    logic tot;
    tot = (^word) ^ pbit;
    case (mode)
      PAR_ODD:  parity_good = tot;
      PAR_EVEN: parity_good = ~tot;
      PAR_ZERO: parity_good = ~pbit;
      PAR_ONE:  parity_good = pbit;
      default:  parity_good = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign dout = chain[STAGES-1];
  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/urx_timer.sv
module urx_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             strobe
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] per_q;

  assign strobe = run && (cnt == PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      per_q <= '0;
    end else if (start) begin
      per_q <= period;
      cnt   <= period >> 1;
    end else if (run) begin
      if (cnt == PER_W'(1)) cnt <= per_q;
      else                  cnt <= cnt - PER_W'(1);
    end
  end
endmodule

// File: rtl/urx_shift.sv
module urx_shift #(
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          shift,
  input  logic          bit_i,
  input  logic          msb_first,
  input  logic [3:0]    nbits,
  output logic [DW-1:0] word
);
  logic [DW-1:0] lsb_nxt;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      if (i == int'(nbits) - 1)           lsb_nxt[i] = bit_i;
      else if (i < int'(nbits) - 1)       lsb_nxt[i] = word[i+1];
      else                                lsb_nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) word <= '0;
    else if (shift) begin
      if (msb_first) word <= {word[DW-2:0], bit_i};
      else           word <= lsb_nxt;
    end
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import urx_pkg::*;
#(
  parameter int unsigned PER_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rxd_i,
  input  logic [PER_W-1:0]    cfg_period_i,
  input  logic [3:0]          cfg_nbits_i,
  input  logic                cfg_msb_first_i,
  input  logic [2:0]          cfg_parity_i,
  output logic [WORD_MAX-1:0] data_o,
  output logic                valid_o,
  output logic                start_err_o,
  output logic                parity_err_o,
  output logic                stop_err_o
);
  localparam int unsigned IDX_W = $clog2(WORD_MAX + 3);

  rx_state_e           state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [3:0]          nbits_q;
  logic                msb_q;
  par_mode_e           par_q;
  logic                start_bad_q;
  logic                par_bad_q;

  logic                line;
  logic                fall;
  logic                strobe;
  logic                open_frame;
  logic                in_data;
  logic [WORD_MAX-1:0] word;
  logic [3:0]          nbits_in;
  par_mode_e           par_in;
  logic [IDX_W-1:0]    last_idx;

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd_i), .dout(line), .fall(fall)
  );

  assign open_frame = (state_q == RX_IDLE) && fall;

  urx_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .start(open_frame), .run(state_q == RX_RUN),
    .period(cfg_period_i), .strobe(strobe)
  );

  assign in_data = strobe && (idx_q != '0) && (IDX_W'(nbits_q) >= idx_q);

  urx_shift #(.DW(WORD_MAX)) u_shift (
    .clk(clk), .rst(rst), .clear(open_frame), .shift(in_data),
    .bit_i(line), .msb_first(msb_q), .nbits(nbits_q), .word(word)
  );

  // Clamp the word length into the supported range.
  always_comb begin
    if (cfg_nbits_i < 4'(WORD_MIN))      nbits_in = 4'(WORD_MIN);
    else if (cfg_nbits_i > 4'(WORD_MAX)) nbits_in = 4'(WORD_MAX);
    else                                 nbits_in = cfg_nbits_i;
  end

  always_comb begin
    case (cfg_parity_i)
      3'd1:    par_in = PAR_ODD;
      3'd2:    par_in = PAR_EVEN;
      3'd3:    par_in = PAR_ZERO;
      3'd4:    par_in = PAR_ONE;
      default: par_in = PAR_NONE;
    endcase
  end

  assign last_idx = IDX_W'(nbits_q) + IDX_W'(1) + IDX_W'(par_q != PAR_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= RX_IDLE;
      idx_q        <= '0;
      nbits_q      <= 4'd8;
      msb_q        <= 1'b0;
      par_q        <= PAR_NONE;
      start_bad_q  <= 1'b0;
      par_bad_q    <= 1'b0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      start_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      stop_err_o   <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      start_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      stop_err_o   <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (fall) begin
            state_q     <= RX_RUN;
            idx_q       <= '0;
            nbits_q     <= nbits_in;
            msb_q       <= cfg_msb_first_i;
            par_q       <= par_in;
            start_bad_q <= 1'b0;
            par_bad_q   <= 1'b0;
          end
        end
        RX_RUN: begin
          if (strobe) begin
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == '0) begin
              start_bad_q <= line;
            end else if (idx_q == last_idx) begin
              valid_o      <= 1'b1;
              data_o       <= word;
              start_err_o  <= start_bad_q;
              parity_err_o <= par_bad_q;
              stop_err_o   <= ~line;
              state_q      <= RX_IDLE;
            end else if (idx_q > IDX_W'(nbits_q)) begin
              par_bad_q <= ~parity_good(par_q, line, word);
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/urx_checker.sv
module urx_checker (
  input logic       clk,
  input logic       rst,
  input logic [8:0] data_o,
  input logic       valid_o,
  input logic       start_err_o,
  input logic       parity_err_o,
  input logic       stop_err_o,
  input logic [3:0] nbits_q,
  input logic [2:0] par_q
);
  a_r12_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r12_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    (start_err_o || parity_err_o || stop_err_o) |-> valid_o);

  a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((data_o >> nbits_q) == 9'd0));

  a_r7_no_parity_flag: assert property (@(posedge clk) disable iff (rst)
    (valid_o && par_q == 3'd0) |-> !parity_err_o);

  a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && data_o == 9'd0 && !stop_err_o));
endmodule

bind uart_frame_rx urx_checker u_chk (
  .clk(clk), .rst(rst), .data_o(data_o), .valid_o(valid_o),
  .start_err_o(start_err_o), .parity_err_o(parity_err_o),
  .stop_err_o(stop_err_o), .nbits_q(nbits_q), .par_q(par_q)
);

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 16;
  localparam int HALF = P / 2;

  typedef struct {
    int data;
    bit se;
    bit pe;
    bit so;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic [15:0] cfg_period = 16'(P);
  logic [3:0]  cfg_nbits = 4'd8;
  logic        cfg_msb = 1'b0;
  logic [2:0]  cfg_par = 3'd0;
  logic [8:0]  data_o;
  logic        valid_o, start_err_o, parity_err_o, stop_err_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   vcyc = 0;
  int   vcount = 0;
  int   last_t0 = 0;
  bit   done = 0;
  bit   prev_valid = 0;
  exp_t exp_q[$];

  uart_frame_rx u_uart_frame_rx (
    .clk(clk), .rst(rst), .rxd_i(rxd), .cfg_period_i(cfg_period),
    .cfg_nbits_i(cfg_nbits), .cfg_msb_first_i(cfg_msb),
    .cfg_parity_i(cfg_par), .data_o(data_o), .valid_o(valid_o),
    .start_err_o(start_err_o), .parity_err_o(parity_err_o),
    .stop_err_o(stop_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard at each valid pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_valid) chk(!valid_o, "R12", "valid longer than one cycle", valid_o, 0);
      if (!valid_o && (start_err_o || parity_err_o || stop_err_o))
        chk(0, "R12", "flag without valid", 1, 0);
      if (valid_o) begin
        vcyc = cyc;
        vcount++;
        if (exp_q.size() == 0) chk(0, "R1", "unexpected valid", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(data_o) == e.data, "R3/R4", "data", data_o, e.data);
          chk(start_err_o == e.se, "R8", "start flag", start_err_o, e.se);
          chk(parity_err_o == e.pe, "R5/R6/R7", "parity flag", parity_err_o, e.pe);
          chk(stop_err_o == e.so, "R9", "stop flag", stop_err_o, e.so);
        end
      end
      prev_valid = valid_o;
    end else prev_valid = 0;
  end

  task automatic drive_bit(input bit b);
    rxd = b;
    repeat (P) @(negedge clk);
  endtask

  // Driver: pushes the expected result, then serialises the frame.
  task automatic send_frame(input int val, input int nb, input bit msb,
                            input int par, input bit bad_par,
                            input bit bad_start, input bit bad_stop,
                            input bit chg_mid);
    int d;
    bit p;
    exp_t e;
    cfg_nbits = 4'(nb);
    cfg_msb   = msb;
    cfg_par   = 3'(par);
    d = val & ((1 << nb) - 1);
    case (par)
      1: p = ($countones(d) % 2) == 0;
      2: p = ($countones(d) % 2) == 1;
      4: p = 1'b1;
      default: p = 1'b0;
    endcase
    if (bad_par) p = !p;
    e.data = d;
    e.se = bad_start;
    e.pe = bad_par && (par != 0);
    e.so = bad_stop;
    exp_q.push_back(e);
    last_t0 = cyc;
    if (bad_start) begin
      rxd = 1'b0;
      repeat (2) @(negedge clk);
      rxd = 1'b1;
      repeat (P - 2) @(negedge clk);
    end else drive_bit(1'b0);
    if (chg_mid) begin
      cfg_nbits = (nb == 9) ? 4'd5 : 4'd9;
      cfg_msb   = !msb;
      cfg_par   = (par == 0) ? 3'd2 : 3'd0;
    end
    for (int i = 0; i < nb; i++) begin
      if (msb) drive_bit(((d >> (nb - 1 - i)) & 1) != 0);
      else     drive_bit(((d >> i) & 1) != 0);
    end
    if (par != 0) drive_bit(p);
    drive_bit(!bad_stop);
    rxd = 1'b1;
    repeat (2 * P) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int vbefore;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(valid_o == 0 && data_o == 0 && !start_err_o && !parity_err_o && !stop_err_o,
        "R11", "reset outputs", data_o, 0);

    // R1: quiet idle line
    repeat (5 * P) @(negedge clk);
    chk(vcount == 0, "R1", "valid on idle line", vcount, 0);

    // R2, R4, R7: 8-bit LSB-first no parity, with exact valid cycle
    send_frame(32'hA5, 8, 0, 0, 0, 0, 0, 0);
    chk(vcyc - last_t0 == 3 + HALF + 9 * P, "R2", "valid cycle", vcyc - last_t0, 3 + HALF + 9 * P);

    // R4: MSB-first
    send_frame(32'h3C, 8, 1, 0, 0, 0, 0, 0);
    send_frame(32'h01, 6, 1, 0, 0, 0, 0, 0);

    // R3, R5: short odd word, long even word, timing with parity
    send_frame(32'h13, 5, 0, 1, 0, 0, 0, 0);
    chk(vcyc - last_t0 == 3 + HALF + 7 * P, "R2", "valid cycle with parity", vcyc - last_t0, 3 + HALF + 7 * P);
    send_frame(32'h1A7, 9, 1, 2, 0, 0, 0, 0);
    send_frame(32'h1A7, 9, 0, 1, 1, 0, 0, 0);
    send_frame(32'h55, 7, 0, 2, 1, 0, 0, 0);

    // R6: forced parity modes
    send_frame(32'hF0, 8, 0, 3, 0, 0, 0, 0);
    send_frame(32'hF0, 8, 0, 3, 1, 0, 0, 0);
    send_frame(32'h0F, 8, 1, 4, 0, 0, 0, 0);
    send_frame(32'h0F, 8, 1, 4, 1, 0, 0, 0);

    // R8: start bit high, frame still decoded
    send_frame(32'h5A, 7, 0, 2, 0, 1, 0, 0);

    // R9: bad stop, then a clean frame
    send_frame(32'h81, 8, 0, 0, 0, 0, 1, 0);
    send_frame(32'h7E, 8, 0, 1, 0, 0, 0, 0);

    // R10: configuration changes mid-frame
    send_frame(32'h9C, 8, 0, 1, 0, 0, 0, 1);

    // R11: reset in the middle of a frame abandons it
    vbefore = vcount;
    rxd = 1'b0;
    repeat (P + HALF) @(negedge clk);
    rxd = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(data_o == 0 && !valid_o, "R11", "outputs after mid-frame reset", data_o, 0);
    repeat (14 * P) @(negedge clk);
    chk(vcount == vbefore, "R11", "valid after abandoned frame", vcount, vbefore);
    send_frame(32'h42, 8, 0, 0, 0, 0, 0, 0);

    chk(exp_q.size() == 0, "R9", "frames not delivered", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule